// File: doc/BRIEF.md
# Masked Sticky Interrupt Controller for Data-Detection Events

This block gathers one-cycle event strobes from four data-detection sources and reduces them to a single active-high interrupt request. Each source owns three single bits: an enable in the mask byte, a sticky flag in the status byte, and a self-clearing strobe in the clear byte. All three bytes use the same bit positions for a given source: source k sits at bit 2k, which gives bits 0, 2, 4 and 6.

A host reaches the three bytes through a plain register port. The port has an address, a write enable, write data, and read data that is combinational from the stored state. The intended flow is as follows. The host enables a source. The source raises its event, which sets the sticky flag. The request output rises. The host reads the status byte and services the source. It then writes a 1 to that source's bit in the clear byte, which drops the request. The request output is a registered level. The physical pin polarity and the bus protocol belong to the surrounding logic.

Top module: `vbi_irq_ctrl`

## Requirements
- R1: After a clock edge with `rst_n` low, every mask bit and every status bit reads 0 and `irq` is 0.
- R2: Address 0x50 holds the mask byte. It is readable and writable at bits 0, 2, 4 and 6, for sources 0 to 3 in that order. Its other bits read 0 whatever was written to them.
- R3: A source event seen while that source's mask bit is 1 sets its status bit (address 0x4E, same bit position) at the next clock edge. The bit then stays set with no further event.
- R4: A source event seen while that source's mask bit is 0 leaves its status bit at 0.
- R5: Writing to address 0x4F clears, at the next edge, every status bit whose write-data bit at that position is 1. Bits written 0 are unaffected. Reads of 0x4F return 0.
- R6: If a clear and a masked-in event for the same source coincide in one cycle, the status bit ends set.
- R7: A mask write that turns a source's mask bit from 0 to 1 clears that source's status bit.
- R8: `irq` equals the OR over sources of (status AND mask), delayed by one clock cycle.
- R9: Writes to the status address change nothing. Reads of any address other than 0x4E and 0x50 return 0.
- R10: Turning a mask bit from 1 to 0 keeps that source's status bit, but its contribution to `irq` is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | 4 | One strobe per source, bit k for source k |
| reg_addr | input | 8 | Register address |
| reg_we | input | 1 | Write enable, one write per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request, active high, registered |

## Verification
The core path is swept over all 256 pairs of mask pattern and event pattern. This shows whether an event sets its own flag and only that flag, and whether masked-out sources stay silent. A second full sweep pairs every set of pending flags with every clear pattern, which exposes a clear bit landing at the wrong position or wiping neighbours. Further sweeps put each event pattern against a full clear in the same cycle, to check event priority. They also walk every mask pattern across pending flags, to separate clearing on enable from keeping flags on disable. Stray writes to the status byte and reads of unused addresses and bits confirm that those return zero and leave state untouched.

// File: rtl/vbi_irq_pkg.sv
// Package: shared constants and helpers for the sticky interrupt controller.
// Assumes sources are spaced a fixed stride apart inside each register byte.
package vbi_irq_pkg;

    // Distance in bits between neighbouring sources inside a register byte.
    localparam int SRC_STRIDE = 2;

    // Per-source control derived from the register port in one cycle.
    typedef struct packed {
        logic mask_we;   // mask byte is being written
        logic mask_bit;  // value written to this source's mask position
        logic clr;       // clear strobe for this source's status
    } src_ctl_t;

    // Bit position of a source inside any of the three register bytes.
    function automatic int src_bit(input int idx);
        return idx * SRC_STRIDE;
    endfunction

endpackage

// File: rtl/irq_regport.sv
// Register port: decodes writes into per-source controls and muxes read data.
// Assumes one access per cycle; read data is combinational from stored state.
module irq_regport
    import vbi_irq_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter int              DATA_W    = 8,
    parameter int              N_SRC     = 4,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h50,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h4E,
    parameter logic [ADDR_W-1:0] CLR_ADDR  = 8'h4F
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [N_SRC-1:0]  mask_vec,
    input  logic [N_SRC-1:0]  stat_vec,
    output src_ctl_t          ctl [N_SRC],
    output logic [DATA_W-1:0] reg_rdata
);

    logic hit_mask;
    logic hit_stat;
    logic hit_clr;

    // Address match for each of the three bytes.
    always_comb begin
        hit_mask = (reg_addr == MASK_ADDR);
        hit_stat = (reg_addr == STAT_ADDR);
        hit_clr  = (reg_addr == CLR_ADDR);
    end

    // Per-source write decode; status writes deliberately produce nothing.
    for (genvar k = 0; k < N_SRC; k++) begin : g_ctl
        localparam int BIT = src_bit(k);
        always_comb begin
            ctl[k].mask_we  = reg_we && hit_mask;
            ctl[k].mask_bit = reg_wdata[BIT];
            ctl[k].clr      = reg_we && hit_clr && reg_wdata[BIT];
        end
    end

    // Read mux: spread mask or status onto their positions, zero elsewhere.
    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < N_SRC; k++) begin
            if (hit_mask) reg_rdata[src_bit(k)] = mask_vec[k];
            if (hit_stat) reg_rdata[src_bit(k)] = stat_vec[k];
        end
    end

endmodule

// File: rtl/irq_src_cell.sv
// One source: holds its mask bit and sticky status bit.
// Assumes the event is a synchronous strobe; an enabled event beats a clear.
module irq_src_cell
    import vbi_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     evt,
    input  src_ctl_t ctl,
    output logic     mask_q,
    output logic     stat_q
);

    logic mask_rise;

    // Detect a mask write that enables a currently disabled source.
    always_comb mask_rise = ctl.mask_we && ctl.mask_bit && !mask_q;

    // Mask bit storage.
    always_ff @(posedge clk) begin
        if (!rst_n)          mask_q <= 1'b0;
        else if (ctl.mask_we) mask_q <= ctl.mask_bit;
    end

    // Sticky status: set by enabled event, cleared by strobe or enable edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                    stat_q <= 1'b0;
        else if (evt && mask_q)        stat_q <= 1'b1;
        else if (ctl.clr || mask_rise) stat_q <= 1'b0;
    end

    assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && mask_q) |=> stat_q);
    assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_q && !stat_q) |=> !stat_q);
    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.clr && !(evt && mask_q)) |=> !stat_q);
    assert_enable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.mask_we && ctl.mask_bit && !mask_q) |=> !stat_q);

endmodule

// File: rtl/irq_out_stage.sv
// Output stage: ORs enabled pending flags and registers the request.
// Assumes flags and masks come straight from the source cells.
module irq_out_stage #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] mask_vec,
    input  logic [N_SRC-1:0] stat_vec,
    output logic             irq
);

    logic any_pending;

    // Any source both pending and enabled.
    always_comb any_pending = |(mask_vec & stat_vec);

    // Register the request level.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= any_pending;
    end

    assert_irq_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(mask_vec & stat_vec))));
    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> !irq);

endmodule

// File: rtl/vbi_irq_ctrl.sv
// Top: four-source masked sticky interrupt controller with a register port.
// Assumes synchronous active-low reset and single-cycle event strobes.
module vbi_irq_ctrl
    import vbi_irq_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter int              DATA_W    = 8,
    parameter int              N_SRC     = 4,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h50,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h4E,
    parameter logic [ADDR_W-1:0] CLR_ADDR  = 8'h4F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_evt,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    src_ctl_t         ctl [N_SRC];
    logic [N_SRC-1:0] mask_vec;
    logic [N_SRC-1:0] stat_vec;

    irq_regport #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SRC(N_SRC),
        .MASK_ADDR(MASK_ADDR), .STAT_ADDR(STAT_ADDR), .CLR_ADDR(CLR_ADDR)
    ) u_port (
        .reg_addr (reg_addr),
        .reg_we   (reg_we),
        .reg_wdata(reg_wdata),
        .mask_vec (mask_vec),
        .stat_vec (stat_vec),
        .ctl      (ctl),
        .reg_rdata(reg_rdata)
    );

    // One cell per source.
    for (genvar k = 0; k < N_SRC; k++) begin : g_src
        irq_src_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (src_evt[k]),
            .ctl   (ctl[k]),
            .mask_q(mask_vec[k]),
            .stat_q(stat_vec[k])
        );
    end

    irq_out_stage #(.N_SRC(N_SRC)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_vec(mask_vec),
        .stat_vec(stat_vec),
        .irq     (irq)
    );

    assert_stat_write_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == STAT_ADDR && src_evt == '0) |=> $stable(stat_vec));
    assert_disable_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == MASK_ADDR && stat_vec[0] && !reg_wdata[0]) |=> stat_vec[0]);

endmodule

// File: tb/vbi_irq_ctrl_tb.sv
module vbi_irq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_evt = '0;
    logic [7:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [7:0] A_MASK = 8'h50;
    localparam logic [7:0] A_STAT = 8'h4E;
    localparam logic [7:0] A_CLR  = 8'h4F;

    always #2 clk = ~clk;

    vbi_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [7:0] spread(input logic [3:0] n);
        logic [7:0] b = '0;
        for (int i = 0; i < 4; i++) b[2*i] = n[i];
        return b;
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    // Drive one cycle of inputs just after an edge, hold through the next edge.
    task automatic tick(input logic [3:0] e, input logic w, input logic [7:0] a, input logic [7:0] d);
        src_evt = e; reg_we = w; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        src_evt = '0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    // Clear mask and all pending flags.
    task automatic wipe();
        tick(4'h0, 1'b1, A_MASK, 8'h00);
        tick(4'h0, 1'b1, A_CLR, 8'hFF);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        @(posedge clk); #1;
        @(posedge clk); #1;
        rst_n = 1'b1;
        // R1: reset state
        rd(A_MASK, v); check("R1 mask", v, 8'h00);
        rd(A_STAT, v); check("R1 status", v, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);

        // R2 R3 R4 R8: all mask x event patterns
        for (int m = 0; m < 16; m++) begin
            for (int e = 0; e < 16; e++) begin
                wipe();
                tick(4'h0, 1'b1, A_MASK, spread(4'(m)) | 8'hAA);
                rd(A_MASK, v); check("R2 mask readback", v, spread(4'(m)));
                tick(4'(e), 1'b0, A_STAT, 8'h00);
                rd(A_STAT, v); check("R3/R4 status", v, spread(4'(m & e)));
                check("R8 irq not yet", {7'd0, irq}, 8'h00);
                tick(4'h0, 1'b0, A_STAT, 8'h00);
                check("R8 irq", {7'd0, irq}, {7'd0, (m & e) != 0});
            end
        end

        // R5: all pending x clear patterns
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 16; c++) begin
                wipe();
                tick(4'h0, 1'b1, A_MASK, 8'h55);
                tick(4'(s), 1'b0, A_STAT, 8'h00);
                tick(4'h0, 1'b1, A_CLR, spread(4'(c)) | 8'hAA);
                rd(A_STAT, v); check("R5 status after clear", v, spread(4'(s & ~c)));
                rd(A_CLR, v); check("R5 clear reads 0", v, 8'h00);
                tick(4'h0, 1'b0, A_STAT, 8'h00);
                check("R5 irq after clear", {7'd0, irq}, {7'd0, (s & ~c & 15) != 0});
            end
        end

        // R6: event and clear in the same cycle
        for (int e = 0; e < 16; e++) begin
            wipe();
            tick(4'h0, 1'b1, A_MASK, 8'h55);
            tick(4'hF, 1'b0, A_STAT, 8'h00);
            tick(4'(e), 1'b1, A_CLR, 8'h55);
            rd(A_STAT, v); check("R6 event wins", v, spread(4'(e)));
        end

        // R7 R10: disable keeps flags, re-enable clears them
        for (int m = 0; m < 16; m++) begin
            wipe();
            tick(4'h0, 1'b1, A_MASK, 8'h55);
            tick(4'hF, 1'b0, A_STAT, 8'h00);
            tick(4'h0, 1'b1, A_MASK, 8'h00);
            rd(A_STAT, v); check("R10 status kept", v, 8'h55);
            tick(4'h0, 1'b0, A_STAT, 8'h00);
            check("R10 irq dropped", {7'd0, irq}, 8'h00);
            tick(4'h0, 1'b1, A_MASK, spread(4'(m)));
            rd(A_STAT, v); check("R7 enable clears", v, spread(4'(~m)));
            tick(4'h0, 1'b0, A_STAT, 8'h00);
            check("R7 irq", {7'd0, irq}, 8'h00);
        end

        // R9: status writes inert, unused addresses read 0
        for (int s = 0; s < 16; s++) begin
            wipe();
            tick(4'h0, 1'b1, A_MASK, 8'h55);
            tick(4'(s), 1'b0, A_STAT, 8'h00);
            tick(4'h0, 1'b1, A_STAT, 8'hFF);
            tick(4'h0, 1'b1, A_STAT, 8'h00);
            rd(A_STAT, v); check("R9 status unchanged", v, spread(4'(s)));
            rd(A_MASK, v); check("R9 mask unchanged", v, 8'h55);
        end
        rd(8'h00, v); check("R9 addr 00", v, 8'h00);
        rd(8'h51, v); check("R9 addr 51", v, 8'h00);
        rd(8'h4D, v); check("R9 addr 4D", v, 8'h00);

        // R1: reset while pending
        tick(4'h0, 1'b0, A_STAT, 8'h00);
        rst_n = 1'b0;
        tick(4'h0, 1'b0, A_STAT, 8'h00);
        rst_n = 1'b1;
        rd(A_STAT, v); check("R1 status after reset", v, 8'h00);
        rd(A_MASK, v); check("R1 mask after reset", v, 8'h00);
        check("R1 irq after reset", {7'd0, irq}, 8'h00);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule